// File: doc/BRIEF.md
# Serial Command Decoder for a Stereo Volume and Tone Processor

This block is a write-only two-wire bus slave that turns host command bytes into the control settings of a stereo audio processor. It oversamples the bus clock and data lines on the system clock, cleans them up with a synchronizer and a glitch filter, and recognises start, repeated-start and stop conditions. The address byte is checked against a fixed 7-bit address with one bit taken from a strap input. Only write transfers are accepted.

Each data byte after the address carries its own opcode in its upper bits, so a single transfer can mix volume, tone and input commands in any order, with no limit on their number. Each accepted byte updates one register, and a one-cycle strobe names that register. The outputs are two volume stages (coarse step, fine step, mute), signed treble, middle and bass levels, the selected stereo input and the soft-mute mode.

Top module: `audioCmdSlave`

## Requirements
- R1: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Data bits are sampled on the rising edge of SCL, MSB first, eight bits per byte. A repeated start is handled exactly like a start.
- R2: The address byte must be 1,0,0,0,0,1,S,0 from MSB to LSB, where S is the level of `addrStrap`. Any other address, including one with the read bit set, gets no acknowledge, and every byte that follows is ignored until the next start.
- R3: `sdaOe` is high (SDA pulled low) for the ninth clock after a matching address and after each data byte of that transfer. It is low at all other times, and it is asserted only while SCL is low.
- R4: A data byte with bit 7 = 0 is a volume command. Bit 0 selects volume 1 (0) or volume 2 (1). Bits 6..4 are the coarse step in units of 8 dB, and bits 3..1 are the fine step in units of 1 dB. Both fields are output unchanged.
- R5: A coarse value of 6 or 7 mutes that volume stage (`volXMute` = 1). Coarse values 0 to 5 leave it unmuted.
- R6: Bits 7..5 = 100, 101 and 110 write treble, middle and bass. Bit 4 is the sign (1 = cut) and bits 3..0 are the magnitude in dB. A magnitude of 15 saturates to 14. Each level is output as 5-bit two's complement in the range -14 to +14.
- R7: Bits 7..5 = 111 write the mute/input register. Bits 1..0 select soft mute: 00 gives `softMuteMode` = 0 (slow), 01 gives 1 (fast), and 1x gives 2 (off). Bits 3..2 select the input: 11 = IN1, 10 = IN2, 01 = IN3. `inputSel` carries the same code.
- R8: A mute/input byte whose input field is 00 updates the soft-mute mode and keeps the previously selected input.
- R9: After reset: both volumes have coarse 7, fine 0 and mute 1; all tone levels are -14; `inputSel` = 11 (IN1); `softMuteMode` = 2 (off).
- R10: Register outputs change only one cycle after the eighth bit of a data byte is sampled. In that same cycle, `updStrobe` pulses for one cycle with exactly one bit set: bit 0 for volume 1, bit 1 for volume 2, bit 2 for treble, bit 3 for middle, bit 4 for bass, bit 5 for mute/input.
- R11: Any number of data bytes may follow the address within one transfer. Each byte is decoded and acknowledged on its own.
- R12: Pulses on SCL or SDA that last fewer than `FILT_LEN` system clocks have no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20 times the SCL bit rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as sampled |
| sdaIn | input | 1 | Bus data line as sampled |
| addrStrap | input | 1 | Address strap bit |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| vol1Coarse | output | 3 | Volume 1 coarse step (8 dB units) |
| vol1Fine | output | 3 | Volume 1 fine step (1 dB units) |
| vol1Mute | output | 1 | Volume 1 muted |
| vol2Coarse | output | 3 | Volume 2 coarse step |
| vol2Fine | output | 3 | Volume 2 fine step |
| vol2Mute | output | 1 | Volume 2 muted |
| trebleLvl | output | 5 | Treble level in dB, two's complement |
| middleLvl | output | 5 | Middle level in dB, two's complement |
| bassLvl | output | 5 | Bass level in dB, two's complement |
| inputSel | output | 2 | Selected input code (11 IN1, 10 IN2, 01 IN3) |
| softMuteMode | output | 2 | 0 slow, 1 fast, 2 off |
| updStrobe | output | 6 | One-cycle register update strobe |

## Verification
The assertions check on every cycle that the update strobe is one-hot or zero, and that no volume register moves without its strobe bit. They also check that tone levels stay within ±14, that the input and soft-mute codes never take an illegal value, and that the acknowledge drive only begins while SCL is low. The bench's bus scenarios are what show the rest. They show that address matching depends on the strap and on the read bit, that rejected transfers stay silent until a new start, and that mixed streams and repeated starts decode correctly. They also show that sub-filter glitches on either line leave decoding intact.

// File: rtl/audioCmdPkg.sv
package audioCmdPkg;
  localparam int NUM_VOL  = 2;
  localparam int NUM_TONE = 3;
  localparam int NUM_REGS = NUM_VOL + NUM_TONE + 1;
  localparam int TONE_W   = 5;
  localparam int STB_TONE = NUM_VOL;
  localparam int STB_MUX  = NUM_VOL + NUM_TONE;

  typedef enum logic [1:0] {
    SM_SLOW = 2'd0,
    SM_FAST = 2'd1,
    SM_OFF  = 2'd2
  } softMode_e;

  // strobe bundle from bus control to register datapath
  typedef struct packed {
    logic       byteValid;
    logic [7:0] byteData;
  } busCmd_t;
endpackage

// File: rtl/audioBusCtrl.sv
module audioBusCtrl
  import audioCmdPkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter logic [5:0] ADDR_HI = 6'b100001
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    addrStrap,
  output busCmd_t cmd,
  output logic    sdaOe
);
  localparam int CNT_W = $clog2(FILT_LEN) + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_ACK_WAIT, ST_ACK, ST_SKIP
  } busState_e;

  logic [1:0] rawIn;
  logic [1:0] filtV;
  assign rawIn = {sdaIn, sclIn};

  // per line: two-flop synchronizer then persistence filter
  for (genvar g = 0; g < 2; g++) begin : gLine
    logic [1:0]       syncQ;
    logic [CNT_W-1:0] cnt;
    logic             filt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= 2'b11;
        cnt   <= '0;
        filt  <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[g]};
        if (syncQ[1] == filt) begin
          cnt <= '0;
        end else if (cnt == CNT_W'(FILT_LEN - 1)) begin
          filt <= syncQ[1];
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign filtV[g] = filt;
  end

  logic sclF, sdaF, sclQ, sdaQ;
  assign sclF = filtV[0];
  assign sdaF = filtV[1];

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startDet = sclF & sclQ & sdaQ & ~sdaF;
  assign stopDet  = sclF & sclQ & ~sdaQ & sdaF;

  busState_e  state;
  logic [2:0] bitCnt;
  logic [7:0] shiftQ;
  logic [7:0] nextByte;
  assign nextByte = {shiftQ[6:0], sdaF};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ   <= 1'b1;
      sdaQ   <= 1'b1;
      state  <= ST_IDLE;
      bitCnt <= '0;
      shiftQ <= '0;
      sdaOe  <= 1'b0;
      cmd    <= '0;
    end else begin
      sclQ          <= sclF;
      sdaQ          <= sdaF;
      cmd.byteValid <= 1'b0;
      if (stopDet) begin
        state <= ST_IDLE;
        sdaOe <= 1'b0;
      end else if (startDet) begin
        state  <= ST_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_DATA: if (sclRise) begin
            shiftQ <= nextByte;
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == 3'd7) begin
              if (state == ST_ADDR) begin
                state <= (nextByte == {ADDR_HI, addrStrap, 1'b0}) ? ST_ACK_WAIT : ST_SKIP;
              end else begin
                cmd.byteValid <= 1'b1;
                cmd.byteData  <= nextByte;
                state         <= ST_ACK_WAIT;
              end
            end
          end
          ST_ACK_WAIT: if (sclFall) begin
            sdaOe <= 1'b1;
            state <= ST_ACK;
          end
          ST_ACK: if (sclFall) begin
            sdaOe  <= 1'b0;
            bitCnt <= '0;
            state  <= ST_DATA;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/audioRegBank.sv
module audioRegBank
  import audioCmdPkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  busCmd_t                             cmd,
  output logic [NUM_VOL-1:0][2:0]             volCoarse,
  output logic [NUM_VOL-1:0][2:0]             volFine,
  output logic [NUM_VOL-1:0]                  volMute,
  output logic [NUM_TONE-1:0][TONE_W-1:0]     toneLvl,
  output logic [1:0]                          inputSel,
  output softMode_e                           softMode,
  output logic [NUM_REGS-1:0]                 updStrobe
);
  localparam logic [TONE_W-1:0] TONE_RESET = TONE_W'(-14);

  logic [7:0]          b;
  logic [NUM_REGS-1:0] hit;
  assign b = cmd.byteData;

  function automatic logic [TONE_W-1:0] toneDecode(input logic [4:0] f);
    logic [TONE_W-1:0] mag;
    mag = (f[3:0] == 4'hF) ? TONE_W'(14) : TONE_W'(f[3:0]);
    return f[4] ? (~mag + 1'b1) : mag;
  endfunction

  for (genvar v = 0; v < NUM_VOL; v++) begin : gVol
    assign hit[v] = cmd.byteValid & ~b[7] & (b[0] == v[0]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        volCoarse[v] <= 3'd7;
        volFine[v]   <= 3'd0;
        volMute[v]   <= 1'b1;
      end else if (hit[v]) begin
        volCoarse[v] <= b[6:4];
        volFine[v]   <= b[3:1];
        volMute[v]   <= (b[6:4] >= 3'd6);
      end
    end
  end

  for (genvar t = 0; t < NUM_TONE; t++) begin : gTone
    assign hit[STB_TONE+t] = cmd.byteValid & b[7] & (b[6:5] == t[1:0]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) toneLvl[t] <= TONE_RESET;
      else if (hit[STB_TONE+t]) toneLvl[t] <= toneDecode(b[4:0]);
    end
  end

  assign hit[STB_MUX] = cmd.byteValid & (&b[7:5]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inputSel  <= 2'b11;
      softMode  <= SM_OFF;
      updStrobe <= '0;
    end else begin
      updStrobe <= hit;
      if (hit[STB_MUX]) begin
        if (b[3:2] != 2'b00) inputSel <= b[3:2];
        softMode <= b[1] ? SM_OFF : (b[0] ? SM_FAST : SM_SLOW);
      end
    end
  end
endmodule

// File: rtl/audioCmdSlave.sv
module audioCmdSlave
  import audioCmdPkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrStrap,
  output logic       sdaOe,
  output logic [2:0] vol1Coarse,
  output logic [2:0] vol1Fine,
  output logic       vol1Mute,
  output logic [2:0] vol2Coarse,
  output logic [2:0] vol2Fine,
  output logic       vol2Mute,
  output logic [4:0] trebleLvl,
  output logic [4:0] middleLvl,
  output logic [4:0] bassLvl,
  output logic [1:0] inputSel,
  output logic [1:0] softMuteMode,
  output logic [5:0] updStrobe
);
  busCmd_t                            cmd;
  logic [NUM_VOL-1:0][2:0]            volCoarse, volFine;
  logic [NUM_VOL-1:0]                 volMute;
  logic [NUM_TONE-1:0][TONE_W-1:0]    toneLvl;
  softMode_e                          softMode;

  audioBusCtrl #(.FILT_LEN(FILT_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrStrap(addrStrap), .cmd(cmd), .sdaOe(sdaOe)
  );

  audioRegBank regs_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .volCoarse(volCoarse), .volFine(volFine), .volMute(volMute),
    .toneLvl(toneLvl), .inputSel(inputSel), .softMode(softMode),
    .updStrobe(updStrobe)
  );

  assign vol1Coarse   = volCoarse[0];
  assign vol1Fine     = volFine[0];
  assign vol1Mute     = volMute[0];
  assign vol2Coarse   = volCoarse[1];
  assign vol2Fine     = volFine[1];
  assign vol2Mute     = volMute[1];
  assign trebleLvl    = toneLvl[0];
  assign middleLvl    = toneLvl[1];
  assign bassLvl      = toneLvl[2];
  assign softMuteMode = softMode;
endmodule

// File: rtl/audioCmdSlave_chk.sv
module audioCmdSlave_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaOe,
  input logic [2:0] vol1Coarse,
  input logic [2:0] vol1Fine,
  input logic       vol1Mute,
  input logic [2:0] vol2Coarse,
  input logic [2:0] vol2Fine,
  input logic       vol2Mute,
  input logic [4:0] trebleLvl,
  input logic [4:0] middleLvl,
  input logic [4:0] bassLvl,
  input logic [1:0] inputSel,
  input logic [1:0] softMuteMode,
  input logic [5:0] updStrobe
);
  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(updStrobe));

  // R10
  vol1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe[0] |-> $stable({vol1Coarse, vol1Fine, vol1Mute}));

  // R10
  vol2_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe[1] |-> $stable({vol2Coarse, vol2Fine, vol2Mute}));

  // R6
  tone_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(trebleLvl) >= -14) && ($signed(trebleLvl) <= 14) &&
    ($signed(middleLvl) >= -14) && ($signed(middleLvl) <= 14) &&
    ($signed(bassLvl) >= -14) && ($signed(bassLvl) <= 14));

  // R7
  mux_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inputSel != 2'b00) && (softMuteMode != 2'b11));

  // R3
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);
endmodule

bind audioCmdSlave audioCmdSlave_chk chk_i (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .vol1Coarse(vol1Coarse), .vol1Fine(vol1Fine), .vol1Mute(vol1Mute),
  .vol2Coarse(vol2Coarse), .vol2Fine(vol2Fine), .vol2Mute(vol2Mute),
  .trebleLvl(trebleLvl), .middleLvl(middleLvl), .bassLvl(bassLvl),
  .inputSel(inputSel), .softMuteMode(softMuteMode), .updStrobe(updStrobe)
);

// File: tb/audioCmdSlave_tb_top.sv
module audioCmdSlave_tb_top;
  localparam int H = 60;
  localparam int Q = 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hScl = 1'b1, hSda = 1'b1, strap = 1'b0;
  logic sdaOe;
  logic [2:0] vol1Coarse, vol1Fine, vol2Coarse, vol2Fine;
  logic vol1Mute, vol2Mute;
  logic [4:0] trebleLvl, middleLvl, bassLvl;
  logic [1:0] inputSel, softMuteMode;
  logic [5:0] updStrobe;
  logic sdaLine;

  always #10 clk = ~clk;
  assign sdaLine = hSda & ~sdaOe;

  audioCmdSlave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(hScl), .sdaIn(sdaLine), .addrStrap(strap),
    .sdaOe(sdaOe), .vol1Coarse(vol1Coarse), .vol1Fine(vol1Fine), .vol1Mute(vol1Mute),
    .vol2Coarse(vol2Coarse), .vol2Fine(vol2Fine), .vol2Mute(vol2Mute),
    .trebleLvl(trebleLvl), .middleLvl(middleLvl), .bassLvl(bassLvl),
    .inputSel(inputSel), .softMuteMode(softMuteMode), .updStrobe(updStrobe)
  );

  int checks = 0, errors = 0;
  bit pend = 1'b0, live = 1'b0;
  int eC[2], eF[2], eM[2], eTone[3], eIn, eSm;
  int eStb[6], sStb[6];

  function automatic void modelReset();
    for (int i = 0; i < 2; i++) begin eC[i] = 7; eF[i] = 0; eM[i] = 1; end
    for (int i = 0; i < 3; i++) eTone[i] = -14;
    eIn = 3; eSm = 2;
    for (int i = 0; i < 6; i++) begin eStb[i] = 0; sStb[i] = 0; end
  endfunction

  function automatic void applyByte(input int b);
    if (b < 128) begin
      int v = b % 2;
      eC[v] = (b / 16) % 8;
      eF[v] = (b / 2) % 8;
      eM[v] = (eC[v] >= 6) ? 1 : 0;
      eStb[v]++;
    end else begin
      int sel = (b / 32) % 4;
      if (sel < 3) begin
        int m = b % 16;
        if (m > 14) m = 14;
        eTone[sel] = ((b / 16) % 2 == 1) ? -m : m;
        eStb[2 + sel]++;
      end else begin
        int inp = (b / 4) % 4;
        if (inp != 0) eIn = inp;
        eSm = (b % 4 >= 2) ? 2 : b % 4;
        eStb[5]++;
      end
    end
  endfunction

  function automatic logic [32:0] expVec();
    return {3'(eC[0]), 3'(eF[0]), 1'(eM[0]), 3'(eC[1]), 3'(eF[1]), 1'(eM[1]),
            5'(eTone[0]), 5'(eTone[1]), 5'(eTone[2]), 2'(eIn), 2'(eSm)};
  endfunction

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model compared on every clock
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 6; i++) if (updStrobe[i]) sStb[i]++;
      if (live && !pend) begin
        logic [32:0] act;
        act = {vol1Coarse, vol1Fine, vol1Mute, vol2Coarse, vol2Fine, vol2Mute,
               trebleLvl, middleLvl, bassLvl, inputSel, softMuteMode};
        checks++;
        if (act !== expVec()) begin
          errors++;
          $display("FAIL R10 model compare actual=%h expected=%h", act, expVec());
        end
      end
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic startCond();
    hSda = 1'b1; waitClk(Q);
    hScl = 1'b1; waitClk(H);
    hSda = 1'b0; waitClk(H);
    hScl = 1'b0; waitClk(Q);
  endtask

  task automatic stopCond();
    hSda = 1'b0; waitClk(Q);
    hScl = 1'b1; waitClk(H);
    hSda = 1'b1; waitClk(H);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit expAck, input bit isData,
                          input bit glitch, input string req);
    for (int i = 7; i >= 0; i--) begin
      hSda = b[i];
      waitClk(Q);
      if (glitch && i == 6) begin
        hScl = 1'b1; waitClk(2); hScl = 1'b0; waitClk(Q);
      end
      hScl = 1'b1;
      if (i == 0 && isData && expAck) begin pend = 1'b1; applyByte(int'(b)); end
      waitClk(H / 2);
      chkEq("R3 release", int'(sdaOe), 0);
      if (glitch && i == 6) begin hSda = 1'b1; waitClk(2); hSda = b[i]; end
      waitClk(H / 2);
      hScl = 1'b0;
      waitClk(Q);
    end
    pend = 1'b0;
    hSda = 1'b1;
    waitClk(Q);
    hScl = 1'b1;
    waitClk(H / 2);
    chkEq(req, int'(sdaOe), int'(expAck));
    waitClk(H / 2);
    hScl = 1'b0;
    waitClk(Q);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    modelReset();
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);
    // R9 reset values
    chkEq("R9 vol1Coarse", vol1Coarse, 7);
    chkEq("R9 vol1Mute", vol1Mute, 1);
    chkEq("R9 vol2Mute", vol2Mute, 1);
    chkEq("R9 bass", $signed(bassLvl), -14);
    chkEq("R9 inputSel", inputSel, 3);
    chkEq("R9 softMuteMode", softMuteMode, 2);
    live = 1'b1;

    // mixed stream, strap 0 (R1 R4 R6 R7 R11)
    startCond();
    sendByte(8'h84, 1, 0, 0, "R1 R2 address ack");
    sendByte(8'h26, 1, 1, 0, "R3 ack");
    sendByte(8'h0B, 1, 1, 0, "R3 ack");
    sendByte(8'h89, 1, 1, 0, "R11 ack");
    sendByte(8'hBF, 1, 1, 0, "R11 ack");
    sendByte(8'hCF, 1, 1, 0, "R11 ack");
    sendByte(8'hE9, 1, 1, 0, "R11 ack");
    stopCond();
    chkEq("R4 vol1Coarse", vol1Coarse, 2);
    chkEq("R4 vol1Fine", vol1Fine, 3);
    chkEq("R5 vol1Mute", vol1Mute, 0);
    chkEq("R4 vol2Fine", vol2Fine, 5);
    chkEq("R6 treble", $signed(trebleLvl), 9);
    chkEq("R6 middle saturated cut", $signed(middleLvl), -14);
    chkEq("R6 bass saturated boost", $signed(bassLvl), 14);
    chkEq("R7 inputSel", inputSel, 2);
    chkEq("R7 softMuteMode", softMuteMode, 1);

    // R2 wrong strap bit and read bit
    startCond();
    sendByte(8'h86, 0, 0, 0, "R2 nack strap");
    sendByte(8'h00, 0, 1, 0, "R2 ignored byte");
    stopCond();
    startCond();
    sendByte(8'h85, 0, 0, 0, "R2 nack read");
    sendByte(8'h8E, 0, 1, 0, "R2 ignored byte");
    stopCond();
    chkEq("R2 treble kept", $signed(trebleLvl), 9);
    chkEq("R2 vol1Coarse kept", vol1Coarse, 2);

    // strap 1, mute codes, repeated start, input 00
    strap = 1'b1;
    waitClk(10);
    startCond();
    sendByte(8'h86, 1, 0, 0, "R2 address ack strap");
    sendByte(8'h60, 1, 1, 0, "R3 ack");
    chkEq("R5 coarse 6 mutes", vol1Mute, 1);
    sendByte(8'h71, 1, 1, 0, "R3 ack");
    chkEq("R5 coarse 7 mutes", vol2Mute, 1);
    sendByte(8'h01, 1, 1, 0, "R3 ack");
    chkEq("R5 coarse 0 unmutes", vol2Mute, 0);
    startCond();
    sendByte(8'h86, 1, 0, 0, "R11 repeated start ack");
    sendByte(8'hE0, 1, 1, 0, "R3 ack");
    chkEq("R8 input kept", inputSel, 2);
    chkEq("R8 soft slow", softMuteMode, 0);
    sendByte(8'hEE, 1, 1, 0, "R3 ack");
    chkEq("R7 input IN1", inputSel, 3);
    chkEq("R7 soft off", softMuteMode, 2);
    sendByte(8'hD0, 1, 1, 0, "R3 ack");
    chkEq("R6 cut zero", $signed(bassLvl), 0);
    stopCond();

    // R12 glitches on both lines
    startCond();
    sendByte(8'h86, 1, 0, 0, "R12 address ack");
    sendByte(8'h8A, 1, 1, 1, "R12 ack after glitch");
    sendByte(8'hF5, 1, 1, 0, "R12 later byte ack");
    stopCond();
    chkEq("R12 treble", $signed(trebleLvl), 10);
    chkEq("R12 input IN3", inputSel, 1);

    waitClk(20);
    for (int i = 0; i < 6; i++) chkEq("R10 strobe count", sStb[i], eStb[i]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule